// File: doc/BRIEF.md
# Receive Frame Rule Classifier

This block classifies received frames against a table of match rules and gives one accept or drop decision per frame. Frames arrive one 32-bit word per beat, with markers on the first and last word. Each rule names a word position inside the frame, a per-bit mask and a compare value. A rule also carries flags that say whether a hit accepts the frame, drops it, or is passed over. Rules are ranked by their index, and the lowest-indexed rule that hits decides the outcome.

A match key that does not start on a word boundary is split across two adjacent rules. The base rule holds the upper part of the first word. The rule at the next index is flagged as its continuation and holds the lower part of the following word. The pair hits only when both parts match, and the continuation rule supplies the action. The highest table index is a fixed rule that matches everything and accepts, so every frame gets a decision. A simple write port loads the rules, but only between frames.

Top module: `fr_parser`

## Requirements
- R1: A rule hits when it is enabled, is not flagged as a continuation, and the frame word at its word position (word 0 is the word marked as first), ANDed with the rule mask, equals the rule value. If its accept flag is set, the frame is accepted.
- R2: When several rules hit, the one with the lowest index decides the outcome, and `hit_idx_o` reports that index.
- R3: A deciding rule with its reject flag set drops the frame, even if its accept flag is also set. A rule that hits with neither flag set is passed over, and later rules are considered.
- R4: A rule whose word position lies at or beyond the length of the frame does not hit.
- R5: Index DEPTH-1 holds a fixed rule that always hits and accepts, and it decides whenever no lower rule does. Writes to that index have no effect.
- R6: A rule with its link flag set hits only when it matches and the rule at the next index also matches on its own mask, value and word position. The action then comes from the next rule, and `hit_idx_o` reports the base index. A rule flagged as a continuation never decides on its own.
- R7: After reset every writable rule is disabled. A disabled rule never hits.
- R8: A table write is ignored if it is presented while a word is on the stream, or while a frame is open (between its first word and its last word).
- R9: `verdict_valid_o` pulses high for exactly one cycle, in the cycle after each last-marked word. While it is high, exactly one of `accept_o` and `drop_o` is high.
- R10: A rule whose word position exceeds MAX_OFF_BYTES/4+1 never hits, however long the frame is.
- R11: A frame of a single word, with the first and last markers set together, is classified using only word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_valid_i | input | 1 | Stream word present |
| word_sof_i | input | 1 | Word is the first word of a frame |
| word_eof_i | input | 1 | Word is the last word of a frame |
| word_data_i | input | 32 | Frame word |
| cfg_we_i | input | 1 | Rule write strobe |
| cfg_idx_i | input | $clog2(DEPTH) | Rule index to write |
| cfg_data_i | input | 32 | Compare value |
| cfg_mask_i | input | 32 | Per-bit compare enable |
| cfg_woff_i | input | 8 | Word position within the frame |
| cfg_accept_i | input | 1 | Accept on hit |
| cfg_reject_i | input | 1 | Drop on hit |
| cfg_link_i | input | 1 | Rule needs the next rule to match as well |
| cfg_cont_i | input | 1 | Rule is a continuation of the previous one |
| cfg_en_i | input | 1 | Rule enabled |
| verdict_valid_o | output | 1 | Decision pulse |
| accept_o | output | 1 | Frame accepted |
| drop_o | output | 1 | Frame dropped |
| hit_idx_o | output | $clog2(DEPTH) | Index of the deciding rule |

## Verification
The checker watches, on every cycle, that a decision follows each last word and appears at no other time, that accept and drop never both show together with a decision, and that the fixed fallback rule always accepts. Which rule decides the outcome depends on the table contents and on the words of the frame, so only the bench's scenarios can show it. These scenarios cover ordering by index, reject taking precedence over accept, flagless rules being passed over, split keys, short frames, the word-position limit, and writes that must be ignored. A randomized table and random frames are compared against a model that the bench computes.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam int WORD_W = 32;
  localparam int OFF_W  = 8;

  typedef struct packed {
    logic              en;
    logic              is_cont;
    logic              has_cont;
    logic              accept;
    logic              reject;
    logic [OFF_W-1:0]  woff;
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] data;
  } rule_t;
endpackage

// File: rtl/fr_rule_table.sv
module fr_rule_table
  import fr_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             lock_i,
  input  logic [IDX_W-1:0] idx_i,
  input  rule_t            rule_i,
  output rule_t            rules_o [DEPTH]
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_rule
    if (i == DEPTH - 1) begin : g_fixed
      // catch-all rule: zero mask, zero value, accept
      assign rules_o[i] = '{en: 1'b1, is_cont: 1'b0, has_cont: 1'b0,
                            accept: 1'b1, reject: 1'b0, woff: '0,
                            mask: '0, data: '0};
    end else begin : g_store
      rule_t rule_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rule_q <= '0;
        else if (we_i && !lock_i && idx_i == IDX_W'(i)) rule_q <= rule_i;
      end
      assign rules_o[i] = rule_q;
    end
  end
endmodule

// File: rtl/fr_rule_match.sv
module fr_rule_match
  import fr_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int MAX_WOFF = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic              word_sof_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [OFF_W-1:0]  widx_i,
  input  logic [WORD_W-1:0] mask_i [DEPTH],
  input  logic [WORD_W-1:0] data_i [DEPTH],
  input  logic [OFF_W-1:0]  woff_i [DEPTH],
  output logic [DEPTH-1:0]  seen_o
);
  logic [DEPTH-1:0] seen_q, seen_now;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign seen_now[i] = word_valid_i && woff_i[i] == widx_i &&
                         woff_i[i] <= OFF_W'(MAX_WOFF) &&
                         (word_i & mask_i[i]) == data_i[i];
  end

  // matches so far in this frame, including the current word
  assign seen_o = (word_sof_i ? '0 : seen_q) | seen_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           seen_q <= '0;
    else if (word_valid_i) seen_q <= seen_o;
  end
endmodule

// File: rtl/fr_verdict.sv
module fr_verdict #(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] seen_i,
  input  logic [DEPTH-1:0] en_i,
  input  logic [DEPTH-1:0] is_cont_i,
  input  logic [DEPTH-1:0] has_cont_i,
  input  logic [DEPTH-1:0] accept_i,
  input  logic [DEPTH-1:0] reject_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             drop_o
);
  logic [DEPTH-1:0] hit, act_drop;

  for (genvar i = 0; i < DEPTH; i++) begin : g_hit
    logic base, pair_ok, a_acc, a_rej;
    assign base = en_i[i] && !is_cont_i[i] && seen_i[i];
    if (i == DEPTH - 1) begin : g_last
      assign pair_ok = !has_cont_i[i];
      assign a_acc   = accept_i[i];
      assign a_rej   = reject_i[i];
    end else begin : g_mid
      assign pair_ok = !has_cont_i[i] || seen_i[i+1];
      assign a_acc   = has_cont_i[i] ? accept_i[i+1] : accept_i[i];
      assign a_rej   = has_cont_i[i] ? reject_i[i+1] : reject_i[i];
    end
    assign hit[i]      = base && pair_ok && (a_acc || a_rej);
    assign act_drop[i] = a_rej;
  end

  always_comb begin
    idx_o  = IDX_W'(DEPTH - 1);
    drop_o = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit[i]) begin
        idx_o  = IDX_W'(i);
        drop_o = act_drop[i];
      end
    end
  end
endmodule

// File: rtl/fr_parser.sv
module fr_parser
  import fr_pkg::*;
#(
  parameter int  DEPTH         = 64,
  parameter int  MAX_OFF_BYTES = 64,
  localparam int IDX_W         = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic              word_sof_i,
  input  logic              word_eof_i,
  input  logic [WORD_W-1:0] word_data_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [WORD_W-1:0] cfg_data_i,
  input  logic [WORD_W-1:0] cfg_mask_i,
  input  logic [OFF_W-1:0]  cfg_woff_i,
  input  logic              cfg_accept_i,
  input  logic              cfg_reject_i,
  input  logic              cfg_link_i,
  input  logic              cfg_cont_i,
  input  logic              cfg_en_i,
  output logic              verdict_valid_o,
  output logic              accept_o,
  output logic              drop_o,
  output logic [IDX_W-1:0]  hit_idx_o
);
  localparam int MAX_WOFF = MAX_OFF_BYTES / 4 + 1;
  localparam int CNT_LIM  = MAX_WOFF + 1;

  rule_t rules [DEPTH];
  rule_t wr_rule;
  logic  busy_q, lock;
  logic [OFF_W-1:0] cnt_q, widx;
  logic [DEPTH-1:0] seen, en_v, ic_v, hc_v, acc_v, rej_v;
  logic [WORD_W-1:0] mask_a [DEPTH];
  logic [WORD_W-1:0] data_a [DEPTH];
  logic [OFF_W-1:0]  woff_a [DEPTH];
  logic [IDX_W-1:0]  sel_idx;
  logic              sel_drop;
  logic              last_word;

  assign last_word = word_valid_i && word_eof_i;
  assign lock      = busy_q || word_valid_i;
  assign wr_rule   = '{en: cfg_en_i, is_cont: cfg_cont_i, has_cont: cfg_link_i,
                       accept: cfg_accept_i, reject: cfg_reject_i,
                       woff: cfg_woff_i, mask: cfg_mask_i, data: cfg_data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         busy_q <= 1'b0;
    else if (last_word)                  busy_q <= 1'b0;
    else if (word_valid_i && word_sof_i) busy_q <= 1'b1;
  end

  assign widx = word_sof_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (word_valid_i)
      cnt_q <= (widx >= OFF_W'(CNT_LIM)) ? OFF_W'(CNT_LIM) : widx + 1'b1;
  end

  fr_rule_table #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .lock_i  (lock),
    .idx_i   (cfg_idx_i),
    .rule_i  (wr_rule),
    .rules_o (rules)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_split
    assign en_v[i]   = rules[i].en;
    assign ic_v[i]   = rules[i].is_cont;
    assign hc_v[i]   = rules[i].has_cont;
    assign acc_v[i]  = rules[i].accept;
    assign rej_v[i]  = rules[i].reject;
    assign mask_a[i] = rules[i].mask;
    assign data_a[i] = rules[i].data;
    assign woff_a[i] = rules[i].woff;
  end

  fr_rule_match #(.DEPTH(DEPTH), .MAX_WOFF(MAX_WOFF)) i_match (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_valid_i (word_valid_i),
    .word_sof_i   (word_sof_i),
    .word_i       (word_data_i),
    .widx_i       (widx),
    .mask_i       (mask_a),
    .data_i       (data_a),
    .woff_i       (woff_a),
    .seen_o       (seen)
  );

  fr_verdict #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_verdict (
    .seen_i     (seen),
    .en_i       (en_v),
    .is_cont_i  (ic_v),
    .has_cont_i (hc_v),
    .accept_i   (acc_v),
    .reject_i   (rej_v),
    .idx_o      (sel_idx),
    .drop_o     (sel_drop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      verdict_valid_o <= 1'b0;
      accept_o        <= 1'b0;
      drop_o          <= 1'b0;
      hit_idx_o       <= '0;
    end else begin
      verdict_valid_o <= last_word;
      if (last_word) begin
        accept_o  <= !sel_drop;
        drop_o    <= sel_drop;
        hit_idx_o <= sel_idx;
      end
    end
  end
endmodule

// File: rtl/fr_parser_chk.sv
module fr_parser_chk #(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             word_valid_i,
  input logic             word_eof_i,
  input logic             verdict_valid_o,
  input logic             accept_o,
  input logic             drop_o,
  input logic [IDX_W-1:0] hit_idx_o
);
  AST_VERDICT_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && word_eof_i) |=> verdict_valid_o); // R9
  AST_NO_SPURIOUS_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_valid_i && word_eof_i) |=> !verdict_valid_o); // R9
  AST_SINGLE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_valid_o |-> (accept_o ^ drop_o)); // R9
  AST_FALLBACK_ACCEPTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_valid_o && hit_idx_o == IDX_W'(DEPTH - 1)) |-> accept_o); // R5
endmodule

bind fr_parser fr_parser_chk #(.DEPTH(DEPTH)) i_fr_parser_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .word_valid_i    (word_valid_i),
  .word_eof_i      (word_eof_i),
  .verdict_valid_o (verdict_valid_o),
  .accept_o        (accept_o),
  .drop_o          (drop_o),
  .hit_idx_o       (hit_idx_o)
);

// File: tb/test_fr_parser.sv
module test_fr_parser;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int IDX_W      = 6;
  localparam int MAXW       = 64 / 4 + 1;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        word_valid_i = 0, word_sof_i = 0, word_eof_i = 0;
  logic [31:0] word_data_i = '0;
  logic        cfg_we_i = 0;
  logic [IDX_W-1:0] cfg_idx_i = '0;
  logic [31:0] cfg_data_i = '0, cfg_mask_i = '0;
  logic [7:0]  cfg_woff_i = '0;
  logic        cfg_accept_i = 0, cfg_reject_i = 0, cfg_link_i = 0, cfg_cont_i = 0, cfg_en_i = 0;
  logic        verdict_valid_o, accept_o, drop_o;
  logic [IDX_W-1:0] hit_idx_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_data [DEPTH];
  logic [31:0] m_mask [DEPTH];
  logic [7:0]  m_woff [DEPTH];
  logic        m_en [DEPTH], m_ic [DEPTH], m_hc [DEPTH], m_acc [DEPTH], m_rej [DEPTH];
  logic [31:0] fw [32];
  int          exp_idx;
  logic        exp_drop;
  logic [31:0] pat [4] = '{32'hA5A5_0F0F, 32'h1234_5678, 32'hFFFF_0000, 32'h0000_00C3};

  fr_parser i_fr_parser (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d, logic [31:0] m, int wo,
                    bit acc, bit rej, bit lnk, bit cnt, bit en);
    cfg_we_i = 1; cfg_idx_i = IDX_W'(idx); cfg_data_i = d; cfg_mask_i = m;
    cfg_woff_i = 8'(wo); cfg_accept_i = acc; cfg_reject_i = rej;
    cfg_link_i = lnk; cfg_cont_i = cnt; cfg_en_i = en;
    @(negedge clk_i);
    cfg_we_i = 0;
    if (idx != DEPTH - 1) begin
      m_data[idx] = d; m_mask[idx] = m; m_woff[idx] = 8'(wo);
      m_acc[idx] = acc; m_rej[idx] = rej; m_hc[idx] = lnk; m_ic[idx] = cnt; m_en[idx] = en;
    end
  endtask

  function automatic bit raw(int j, int len);
    if (j == DEPTH - 1) return 1;
    if (m_woff[j] > 8'(MAXW)) return 0;
    if (int'(m_woff[j]) >= len) return 0;
    return (fw[m_woff[j]] & m_mask[j]) == m_data[j];
  endfunction

  function automatic void model(int len);
    exp_idx = DEPTH - 1; exp_drop = 0;
    for (int i = 0; i < DEPTH - 1; i++) begin
      int a;
      bit fa, fr;
      if (!m_en[i] || m_ic[i] || !raw(i, len)) continue;
      if (m_hc[i] && !raw(i + 1, len)) continue;
      a  = m_hc[i] ? i + 1 : i;
      fa = (a == DEPTH - 1) ? 1'b1 : m_acc[a];
      fr = (a == DEPTH - 1) ? 1'b0 : m_rej[a];
      if (fa || fr) begin exp_idx = i; exp_drop = fr; return; end
    end
  endfunction

  task automatic frame(int len, string req);
    for (int k = 0; k < len; k++) begin
      word_valid_i = 1; word_sof_i = (k == 0); word_eof_i = (k == len - 1);
      word_data_i = fw[k];
      @(negedge clk_i);
    end
    word_valid_i = 0; word_sof_i = 0; word_eof_i = 0;
    model(len);
    chk({req, " valid"}, 32'(verdict_valid_o), 1);
    chk({req, " idx"}, 32'(hit_idx_o), 32'(exp_idx));
    chk({req, " drop"}, 32'(drop_o), 32'(exp_drop));
    chk({req, " accept"}, 32'(accept_o), 32'(!exp_drop));
  endtask

  task automatic clear_table();
    for (int i = 0; i < DEPTH - 1; i++) wr(i, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) begin
      m_data[i] = 0; m_mask[i] = 0; m_woff[i] = 0;
      m_en[i] = 0; m_ic[i] = 0; m_hc[i] = 0; m_acc[i] = 0; m_rej[i] = 0;
    end
    for (int i = 0; i < 32; i++) fw[i] = 32'h0;
    #(CLK_PERIOD * 3);
    @(negedge clk_i);
    chk("R9 reset valid", 32'(verdict_valid_o), 0);
    chk("R9 reset accept", 32'(accept_o), 0);
    chk("R9 reset drop", 32'(drop_o), 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R7: empty table after reset, fallback decides (R5)
    fw[0] = 32'h0; fw[1] = 32'h0; fw[2] = 32'h0;
    frame(3, "R7 R5 empty table");
    @(negedge clk_i);
    chk("R9 single pulse", 32'(verdict_valid_o), 0);

    // R1 basic match at word 1
    wr(5, 32'h1234_0000, 32'hFFFF_0000, 1, 1, 0, 0, 0, 1);
    fw[0] = 32'hDEAD_BEEF; fw[1] = 32'h1234_ABCD;
    frame(3, "R1 hit");
    chk("R1 idx direct", 32'(hit_idx_o), 5);
    fw[1] = 32'h1235_ABCD;
    frame(3, "R1 miss");
    chk("R1 miss direct", 32'(hit_idx_o), DEPTH - 1);

    // R2 / R3 ordering and flags
    fw[1] = 32'h1234_0001;
    wr(3, 32'h0000_0001, 32'h0000_00FF, 1, 0, 1, 0, 0, 1);
    frame(3, "R2 R3 lower index drops");
    chk("R2 idx", 32'(hit_idx_o), 3);
    chk("R3 drop", 32'(drop_o), 1);
    wr(3, 32'h0000_0001, 32'h0000_00FF, 1, 1, 1, 0, 0, 1);
    frame(3, "R3 both flags");
    chk("R3 reject wins", 32'(drop_o), 1);
    wr(3, 32'h0000_0001, 32'h0000_00FF, 1, 0, 0, 0, 0, 1);
    frame(3, "R3 no flags");
    chk("R3 passed over", 32'(hit_idx_o), 5);

    // R4 / R11 short frame
    frame(1, "R4 R11 single word");
    chk("R4 short miss", 32'(hit_idx_o), DEPTH - 1);
    wr(7, 32'hDEAD_0000, 32'hFFFF_0000, 0, 0, 1, 0, 0, 1);
    frame(1, "R11 word0 hit");
    chk("R11 idx", 32'(hit_idx_o), 7);

    // R5 write to fixed index ignored
    clear_table();
    wr(DEPTH - 1, 0, 0, 0, 0, 1, 0, 0, 1);
    frame(2, "R5 fixed rule");
    chk("R5 still accepts", 32'(accept_o), 1);

    // R7 disable removes hit
    wr(9, 0, 0, 0, 0, 1, 0, 0, 1);
    frame(2, "R7 enabled");
    chk("R7 enabled hits", 32'(hit_idx_o), 9);
    wr(9, 0, 0, 0, 0, 1, 0, 0, 0);
    frame(2, "R7 disabled");
    chk("R7 disabled misses", 32'(hit_idx_o), DEPTH - 1);

    // R6 split key: 32-bit key at byte 6 -> word 1 upper half, word 2 lower half
    clear_table();
    wr(10, 32'hBEEF_0000, 32'hFFFF_0000, 1, 0, 0, 1, 0, 1);
    wr(11, 32'h0000_CAFE, 32'h0000_FFFF, 2, 0, 1, 0, 1, 1);
    fw[0] = 0; fw[1] = 32'hBEEF_1111; fw[2] = 32'h2222_CAFE; fw[3] = 0;
    frame(4, "R6 both parts");
    chk("R6 base index", 32'(hit_idx_o), 10);
    chk("R6 action from continuation", 32'(drop_o), 1);
    fw[2] = 32'h2222_CAFF;
    frame(4, "R6 only base");
    chk("R6 base alone", 32'(hit_idx_o), DEPTH - 1);
    fw[1] = 32'hBEEE_1111; fw[2] = 32'h2222_CAFE;
    frame(4, "R6 only continuation");
    chk("R6 cont alone", 32'(hit_idx_o), DEPTH - 1);

    // R8 writes during a frame are ignored
    clear_table();
    fw[0] = 1; fw[1] = 2; fw[2] = 3;
    word_valid_i = 1; word_sof_i = 1; word_eof_i = 0; word_data_i = fw[0];
    cfg_we_i = 1; cfg_idx_i = 0; cfg_mask_i = 0; cfg_data_i = 0; cfg_woff_i = 0;
    cfg_reject_i = 1; cfg_accept_i = 0; cfg_link_i = 0; cfg_cont_i = 0; cfg_en_i = 1;
    @(negedge clk_i);
    word_valid_i = 0; word_sof_i = 0; cfg_idx_i = 1;
    @(negedge clk_i);
    word_valid_i = 1; word_eof_i = 1; word_data_i = fw[2]; cfg_idx_i = 2;
    @(negedge clk_i);
    word_valid_i = 0; word_eof_i = 0; cfg_we_i = 0;
    chk("R8 in-flight frame", 32'(hit_idx_o), DEPTH - 1);
    frame(3, "R8 next frame");
    chk("R8 table unchanged", 32'(hit_idx_o), DEPTH - 1);

    // R10 word position limit
    for (int k = 0; k < 20; k++) fw[k] = 32'h55;
    wr(4, 0, 0, MAXW + 1, 0, 1, 0, 0, 1);
    frame(20, "R10 beyond limit");
    chk("R10 no hit", 32'(hit_idx_o), DEPTH - 1);
    wr(6, 0, 0, MAXW, 0, 1, 0, 0, 1);
    frame(20, "R10 at limit");
    chk("R10 limit hits", 32'(hit_idx_o), 6);

    // randomized table and frames, R1 R2 R3 R6 against model
    clear_table();
    for (int i = 0; i < 40; i++) begin
      logic [31:0] m;
      m = $urandom() & $urandom() & $urandom();
      wr(i, pat[$urandom() % 4] & m, m, $urandom() % 6, ($urandom() % 2) == 1,
         ($urandom() % 3) == 0, ($urandom() % 4) == 0, ($urandom() % 5) == 0,
         ($urandom() % 4) != 0);
    end
    for (int n = 0; n < 300; n++) begin
      int len;
      len = 1 + $urandom() % 8;
      for (int k = 0; k < len; k++)
        fw[k] = pat[$urandom() % 4] ^ ((($urandom() % 3) == 0) ? (32'h1 << ($urandom() % 32)) : 32'h0);
      frame(len, "R2 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule